// File: doc/BRIEF.md
# Memory Access Duty-Cycle Throttle

This block sits in front of a memory arbiter and limits how many cycles the memory may be granted. A free-running frame of eight clock cycles repeats without end. A 3-bit throttle code, held in a write-only 16-bit diagnostic register, sets how many cycles at the end of each frame are blocked. A code of k leaves 8−k usable cycles, so a higher code means less memory bandwidth, and code 0 blocks nothing. The usable cycles always come first in the frame and the blocked cycles come last. A new code is applied only at a frame start, so a single frame never uses two settings.

The same register holds a monitor switch. When the switch is on, the external address output carries the internal address bus. When it is off, the output carries the normal external address. The arbiter samples the per-cycle `allow_o` strobe and holds any request that arrives in a blocked cycle. `frame_sync_o` marks the first cycle of each frame.

Top module: `mem_duty_throttle`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `allow_o` is 1, `frame_sync_o` is 1 and `ext_addr_o` is 0. The throttle code and the monitor switch both reset to 0.
- R2: A write (`wr_en`=1 at a clock edge) stores `wr_data[10:8]` as the throttle code and `wr_data[0]` as the monitor switch. The register has no read path.
- R3: Bits 15:11 and 7:1 of `wr_data` are ignored. Writing ones to them changes neither the throttle pattern nor the address selection.
- R4: `frame_sync_o` is high for exactly one cycle in every 8, and frames follow each other without gaps.
- R5: With code k active for a whole frame, `allow_o` is high in exactly 8−k cycles of that frame.
- R6: At frame position p (0 at `frame_sync_o`), `allow_o` is 1 when p < 8−k and 0 otherwise. The usable cycles come first and the blocked cycles come last.
- R7: With code 0, `allow_o` is 1 in every cycle.
- R8: A code written during a frame, in any cycle including the last one, does not change the rest of that frame. It applies from position 0 of the next frame.
- R9: `ext_addr_o` is registered. After each clock edge it equals the value that `int_addr_i` had before that edge when the monitor switch is 1, and the value that `norm_addr_i` had before that edge when the switch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| int_addr_i | input | ADDR_W (16) | Internal address bus |
| norm_addr_i | input | ADDR_W (16) | Normal external address |
| allow_o | output | 1 | High when the memory may be granted in this cycle |
| frame_sync_o | output | 1 | High in the first cycle of each frame |
| ext_addr_o | output | ADDR_W (16) | Selected external address |

## Verification
All eight throttle codes are swept. Each code is checked cycle by cycle over several frames, comparing the frame position against 8−k. This separates an inverted or off-by-one code decode from a wrong placement of the blocked cycles, and the extreme codes 0 and 7 are included. Codes are also written in the middle of a frame and in its last cycle. The remaining cycles of that frame are checked to show the old pattern, which shows whether the change waits for the frame boundary. Writes with every reserved bit set confirm that only bits 10:8 and bit 0 have any effect. Address vectors are applied with the monitor switch off and on to check each leg of the selector.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  // Register layout: the field positions are decoded by software, so they are fixed.
  localparam int REG_W   = 16;
  localparam int SEL_LSB = 8;
  localparam int MON_BIT = 0;
endpackage

// File: rtl/mdt_diag_reg.sv
module mdt_diag_reg #(
  parameter int REG_W   = mdt_pkg::REG_W,
  parameter int SEL_W   = 3,
  parameter int SEL_LSB = mdt_pkg::SEL_LSB,
  parameter int MON_BIT = mdt_pkg::MON_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_d,
  output logic [SEL_W-1:0] sel_q,
  output logic             mon_q
);
  logic mon_d;

  // Only the two fields are stored; every other bit of the write is dropped.
  always_comb begin
    sel_d = sel_q;
    mon_d = mon_q;
    if (wr_en) begin
      sel_d = wr_data[SEL_LSB +: SEL_W];
      mon_d = wr_data[MON_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      mon_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      mon_q <= mon_d;
    end
  end
endmodule

// File: rtl/mdt_frame_ctr.sv
module mdt_frame_ctr #(
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [FRAME_W-1:0] cnt_d,
  output logic               wrap
);
  localparam logic [FRAME_W-1:0] LAST = '1;

  logic [FRAME_W-1:0] cnt_q;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdt_slot_gate.sv
module mdt_slot_gate #(
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] cnt_d,
  input  logic               wrap,
  input  logic [FRAME_W-1:0] sel_d,
  output logic [FRAME_W-1:0] act_sel_q,
  output logic               allow_q,
  output logic               sync_q
);
  localparam int               FRAME_LEN = 1 << FRAME_W;
  localparam logic [FRAME_W:0] LEN_V     = FRAME_LEN[FRAME_W:0];

  logic [FRAME_W-1:0] sel_eff;
  logic [FRAME_W:0]   open_slots;
  logic               allow_d;

  // The code is loaded only while entering position 0. Taking sel_d here
  // means a write in the last cycle still reaches the next frame.
  always_comb begin
    sel_eff    = wrap ? sel_d : act_sel_q;
    open_slots = LEN_V - {1'b0, sel_eff};
    allow_d    = ({1'b0, cnt_d} < open_slots);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel_q <= '0;
      allow_q   <= 1'b1;
      sync_q    <= 1'b1;
    end else begin
      act_sel_q <= sel_eff;
      allow_q   <= allow_d;
      sync_q    <= wrap;
    end
  end
endmodule

// File: rtl/mdt_addr_mux.sv
module mdt_addr_mux #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon,
  input  logic [ADDR_W-1:0] int_addr,
  input  logic [ADDR_W-1:0] norm_addr,
  output logic [ADDR_W-1:0] ext_q
);
  always_ff @(posedge clk) begin
    if (rst)      ext_q <= '0;
    else if (mon) ext_q <= int_addr;
    else          ext_q <= norm_addr;
  end
endmodule

// File: rtl/mem_duty_throttle.sv
module mem_duty_throttle #(
  parameter int ADDR_W  = 16,
  parameter int FRAME_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [mdt_pkg::REG_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        int_addr_i,
  input  logic [ADDR_W-1:0]        norm_addr_i,
  output logic                     allow_o,
  output logic                     frame_sync_o,
  output logic [ADDR_W-1:0]        ext_addr_o
);
  logic [FRAME_W-1:0] sel_d, sel_q, act_sel_q, cnt_d;
  logic               mon_q, wrap;

  mdt_diag_reg #(
    .REG_W  (mdt_pkg::REG_W),
    .SEL_W  (FRAME_W),
    .SEL_LSB(mdt_pkg::SEL_LSB),
    .MON_BIT(mdt_pkg::MON_BIT)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sel_d(sel_d), .sel_q(sel_q), .mon_q(mon_q)
  );

  mdt_frame_ctr #(.FRAME_W(FRAME_W)) u_ctr (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .wrap(wrap)
  );

  mdt_slot_gate #(.FRAME_W(FRAME_W)) u_gate (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .wrap(wrap), .sel_d(sel_d),
    .act_sel_q(act_sel_q), .allow_q(allow_o), .sync_q(frame_sync_o)
  );

  mdt_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst(rst), .mon(mon_q), .int_addr(int_addr_i),
    .norm_addr(norm_addr_i), .ext_q(ext_addr_o)
  );
endmodule

// File: rtl/mem_duty_throttle_chk.sv
module mem_duty_throttle_chk #(
  parameter int ADDR_W  = 16,
  parameter int FRAME_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               allow_o,
  input logic               frame_sync_o,
  input logic [ADDR_W-1:0]  ext_addr_o,
  input logic [ADDR_W-1:0]  int_addr_i,
  input logic [ADDR_W-1:0]  norm_addr_i,
  input logic               mon,
  input logic [FRAME_W-1:0] act_sel
);
  localparam int               FRAME_LEN = 1 << FRAME_W;
  localparam logic [FRAME_W:0] LEN_V     = FRAME_LEN[FRAME_W:0];
  localparam logic [FRAME_W:0] GAP_MAX   = LEN_V - 1'b1;

  logic [FRAME_W:0] gap_q, opens_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      opens_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (frame_sync_o) begin
        gap_q   <= '0;
        opens_q <= {{FRAME_W{1'b0}}, allow_o};
        seen_q  <= 1'b1;
      end else begin
        gap_q   <= gap_q + 1'b1;
        opens_q <= opens_q + {{FRAME_W{1'b0}}, allow_o};
      end
    end
  end

  // R1: the first cycle after reset is the first slot of a frame and is usable
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frame_sync_o && allow_o && ext_addr_o == '0));

  // R4: frame syncs are exactly FRAME_LEN cycles apart
  a_r4_sync_spacing: assert property (@(posedge clk) disable iff (rst)
    (seen_q && frame_sync_o) |-> (gap_q == GAP_MAX));
  a_r4_sync_due: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == GAP_MAX) |-> frame_sync_o);

  // R5: usable cycles in the finished frame match its code
  a_r5_frame_count: assert property (@(posedge clk) disable iff (rst)
    (seen_q && frame_sync_o) |-> (opens_q == LEN_V - {1'b0, $past(act_sel)}));

  // R6: a usable stretch can only begin at the frame start
  a_r6_open_first: assert property (@(posedge clk) disable iff (rst)
    $rose(allow_o) |-> frame_sync_o);

  // R7: code zero leaves every cycle usable
  a_r7_all_open: assert property (@(posedge clk) disable iff (rst)
    (act_sel == '0) |-> allow_o);

  // R8: the applied code stays fixed inside a frame
  a_r8_frame_stable: assert property (@(posedge clk) disable iff (rst)
    !frame_sync_o |-> $stable(act_sel));

  // R9: registered selection of the address source
  a_r9_addr_sel: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ext_addr_o == ($past(mon) ? $past(int_addr_i) : $past(norm_addr_i))));
endmodule

bind mem_duty_throttle mem_duty_throttle_chk #(
  .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .allow_o(allow_o), .frame_sync_o(frame_sync_o),
  .ext_addr_o(ext_addr_o), .int_addr_i(int_addr_i), .norm_addr_i(norm_addr_i),
  .mon(mon_q), .act_sel(act_sel_q)
);

// File: tb/tb_mem_duty_throttle.sv
module tb_mem_duty_throttle;
  localparam int ADDR_W = 16;
  localparam int FLEN   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_data = '0;
  logic [ADDR_W-1:0] int_addr_i = '0;
  logic [ADDR_W-1:0] norm_addr_i = '0;
  logic              allow_o, frame_sync_o;
  logic [ADDR_W-1:0] ext_addr_o;

  int vecs = 0;
  int bad  = 0;

  mem_duty_throttle #(.ADDR_W(ADDR_W), .FRAME_W(3)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .int_addr_i(int_addr_i), .norm_addr_i(norm_addr_i),
    .allow_o(allow_o), .frame_sync_o(frame_sync_o), .ext_addr_o(ext_addr_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    tick();
    wr_en   = 1'b0;
  endtask

  // Leaves the bench at the last position of a frame.
  task automatic to_frame_end();
    tick();
    while (!frame_sync_o) tick();
    for (int i = 0; i < FLEN - 1; i++) tick();
  endtask

  // Checks one frame. If at_start is 0 the bench sits at position 7 of the
  // previous frame; if it is 1 the bench already sits at position 0.
  task automatic frame_chk(input int k, input bit at_start, input string req);
    int opens = 0;
    for (int p = 0; p < FLEN; p++) begin
      if (p > 0 || !at_start) tick();
      chk(allow_o == (p < FLEN - k), req, allow_o, (p < FLEN - k));
      chk(frame_sync_o == (p == 0), "R4", frame_sync_o, (p == 0));
      if (allow_o) opens++;
    end
    chk(opens == FLEN - k, "R5", opens, FLEN - k);
  endtask

  task automatic addr_chk(input bit mon, input string req);
    for (int i = 0; i < 6; i++) begin
      logic [ADDR_W-1:0] a, b, e;
      a = ADDR_W'(16'h1000 + i * 37);
      b = ADDR_W'(16'hA000 ^ (i * 91));
      int_addr_i  = a;
      norm_addr_i = b;
      tick();
      e = mon ? a : b;
      chk(ext_addr_o == e, req, ext_addr_o, e);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    // R1 reset state, during reset and in the first cycle after it
    for (int i = 0; i < 3; i++) tick();
    chk(allow_o == 1'b1, "R1", allow_o, 1);
    chk(frame_sync_o == 1'b1, "R1", frame_sync_o, 1);
    chk(ext_addr_o == '0, "R1", ext_addr_o, 0);
    rst = 1'b0;
    chk(allow_o == 1'b1 && frame_sync_o == 1'b1, "R1", allow_o, 1);
    // the first frame runs with code 0 (R7)
    frame_chk(0, 1'b1, "R7");

    // R2 R5 R6 R7: sweep every code over three frames each
    for (int k = 0; k < FLEN; k++) begin
      wr(16'(k << 8));
      to_frame_end();
      for (int f = 0; f < 3; f++) frame_chk(k, 1'b0, (k == 0) ? "R7" : "R6");
    end

    // R8: write in the middle of a frame that runs with code 0
    wr(16'h0000);
    to_frame_end();
    for (int i = 0; i < 4; i++) tick();          // position 3
    wr_data = 16'h0600;
    wr_en   = 1'b1;
    tick();                                      // position 4
    wr_en   = 1'b0;
    for (int p = 4; p < FLEN; p++) begin
      if (p > 4) tick();
      chk(allow_o == 1'b1, "R8", allow_o, 1);
    end
    frame_chk(6, 1'b0, "R8");
    // R8: write in the last cycle of a frame
    wr(16'h0200);                                // lands at position 0
    frame_chk(2, 1'b1, "R8");
    frame_chk(2, 1'b0, "R8");

    // R9 + R3: reserved ones with both fields at zero
    wr(16'hF8FE);
    to_frame_end();
    frame_chk(0, 1'b0, "R3");
    addr_chk(1'b0, "R3");
    // R2 + R3: all ones gives code 7, monitor on
    wr(16'hFFFF);
    to_frame_end();
    frame_chk(7, 1'b0, "R2");
    addr_chk(1'b1, "R9");
    // R9: monitor off again, clean write with code 1
    wr(16'h0100);
    tick();
    addr_chk(1'b0, "R9");
    to_frame_end();
    frame_chk(1, 1'b0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule